// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block performs one arithmetic operation on every lane of a pair of 32-bit operands at once. A lane-size select splits each operand into four byte lanes, two halfword lanes or one full word. The same operation is applied to every lane, and each lane's result goes back into the bit positions it came from. The operations are:

- modular add and subtract, with signed or unsigned overflow detection;
- signed or unsigned saturating add and subtract;
- halving add and subtract on signed or unsigned lanes, each in a truncating and a rounding form;
- a saturating absolute value of the first operand.

The result is registered. It appears one clock after a valid input, together with an output-valid strobe. A sticky status bit collects every lane event: a clip, a modular overflow, or a most-negative absolute value. That bit stays set until a clear input drops it. A datapath issues one operation per cycle and reads the status bit whenever it needs it.

Top module: `simd_addsub`

## Requirements
- R1: Lane select 2'b00 gives four byte lanes, at bits [31:24], [23:16], [15:8] and [7:0]. 2'b01 gives two halfword lanes, at [31:16] and [15:0]. 2'b10 and 2'b11 treat the operand as one 32-bit word. Lanes never interact, and each result returns to its lane's bit positions.
- R2: The opcode is {sub, mode[3:0]}. Bit 4 set means subtract. Mode 0 is modular with signed overflow detection and mode 1 is modular with unsigned carry/borrow detection. Both return the low lane bits of a op b.
- R3: Mode 2 (signed saturating) clamps a lane result to the largest positive value (0x7F, 0x7FFF, 0x7FFFFFFF) or to the most negative value (0x80, 0x8000, 0x80000000), and flags the clamp.
- R4: Mode 3 (unsigned saturating) clamps an add that carries out to all ones, and a subtract that borrows to zero. Either clamp is flagged.
- R5: Modes 4 (signed lanes) and 6 (unsigned lanes) are truncating halving operations. They return bits [W:1] of the exact W+2-bit sum or difference.
- R6: Modes 5 (signed) and 7 (unsigned) are rounding halving operations. They add 1 to the exact sum or difference before taking bits [W:1]. No halving mode ever raises the status bit.
- R7: Mode 8 returns the per-lane absolute value of operand a and ignores operand b and the subtract bit. A lane holding the most negative value returns the largest positive value and raises the status bit.
- R8: A result, and an out_valid high, appear in the cycle after in_valid is high. When in_valid is low, out_valid drops and the result holds.
- R9: Any flagged lane event in an accepted operation sets sat_flag in the same cycle as that operation's out_valid. The flag then holds until cleared.
- R10: If sat_clear is high and no new event arrives, sat_flag is zero in the next cycle. If a new event and a clear arrive in the same cycle, the flag stays set.
- R11: After a synchronous reset, the result, out_valid and sat_flag are all zero.
- R12: Modes 9 to 15 return a zero result and never raise the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 5 | {subtract, mode[3:0]} |
| lane_sel | input | 2 | 00 bytes, 01 halfwords, 1x word |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| sat_clear | input | 1 | Clears the sticky status bit |
| res | output | 32 | Registered packed result |
| out_valid | output | 1 | res holds a new result |
| sat_flag | output | 1 | Sticky overflow/saturation status |

## Verification
The status bit has two writers that can act in the same cycle: a clear request, and a new operation whose lane clips or overflows. The bench drives directed cycles with sat_clear high alongside a saturating byte add, with sat_clear high alongside a clean add, and with sat_clear high and no valid input. After that it mixes clears, idle cycles and all sixteen modes at random, using lane values biased toward the clamp edges. A behavioural model updates the expected flag on every clock, with set taking precedence over clear, and compares it with sat_flag, res and out_valid.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        M_MOD_S    = 4'd0,
        M_MOD_U    = 4'd1,
        M_SAT_S    = 4'd2,
        M_SAT_U    = 4'd3,
        M_HALF_S   = 4'd4,
        M_HALF_S_R = 4'd5,
        M_HALF_U   = 4'd6,
        M_HALF_U_R = 4'd7,
        M_ABS      = 4'd8
    } mode_e;

    typedef struct packed {
        logic  sub;
        mode_e mode;
    } op_t;

    typedef enum logic [1:0] {
        LS_BYTE = 2'b00,
        LS_HALF = 2'b01,
        LS_WORD = 2'b10,
        LS_WRD2 = 2'b11
    } lane_e;

    function automatic logic is_round(input mode_e m);
        return (m == M_HALF_S_R) || (m == M_HALF_U_R);
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  op_t          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         ovf
);
    localparam int XW = W + 2;
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [XW-1:0] sa, sb, ua, ub, s_sum, u_sum, h_in, h_val;
    logic          s_ovf, u_ovf, rnd;
    logic          unused_bits;

    assign sa    = {{2{a[W-1]}}, a};
    assign sb    = {{2{b[W-1]}}, b};
    assign ua    = {2'b00, a};
    assign ub    = {2'b00, b};
    assign s_sum = op.sub ? (sa - sb) : (sa + sb);
    assign u_sum = op.sub ? (ua - ub) : (ua + ub);
    assign s_ovf = s_sum[W] != s_sum[W-1];
    assign u_ovf = u_sum[W];
    assign rnd   = is_round(op.mode);
    assign h_in  = (op.mode == M_HALF_U || op.mode == M_HALF_U_R) ? u_sum : s_sum;
    assign h_val = h_in + {{(XW-1){1'b0}}, rnd};
    assign unused_bits = ^{h_val[0], h_val[XW-1], u_sum[XW-1]};

    always_comb begin
        y   = '0;
        ovf = 1'b0;
        case (op.mode)
            M_MOD_S: begin
                y   = s_sum[W-1:0];
                ovf = s_ovf;
            end
            M_MOD_U: begin
                y   = u_sum[W-1:0];
                ovf = u_ovf;
            end
            M_SAT_S: begin
                y   = s_ovf ? (s_sum[XW-1] ? SMIN : SMAX) : s_sum[W-1:0];
                ovf = s_ovf;
            end
            M_SAT_U: begin
                y   = u_ovf ? (op.sub ? '0 : '1) : u_sum[W-1:0];
                ovf = u_ovf;
            end
            M_HALF_S, M_HALF_S_R, M_HALF_U, M_HALF_U_R: begin
                y = h_val[W:1];
            end
            M_ABS: begin
                if (a == SMIN) begin
                    y   = SMAX;
                    ovf = 1'b1;
                end else begin
                    y = a[W-1] ? (~a + 1'b1) : a;
                end
            end
            default: begin
                y   = '0;
                ovf = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/simd_bank.sv
module simd_bank
    import simd_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 4
) (
    input  op_t            op,
    input  logic [N*W-1:0] a,
    input  logic [N*W-1:0] b,
    output logic [N*W-1:0] y,
    output logic           ovf_any
);
    logic [N-1:0] lane_ovf;

    for (genvar i = 0; i < N; i++) begin : g_lane
        simd_lane #(.W(W)) u_lane (
            .op  (op),
            .a   (a[i*W +: W]),
            .b   (b[i*W +: W]),
            .y   (y[i*W +: W]),
            .ovf (lane_ovf[i])
        );
    end

    assign ovf_any = |lane_ovf;

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [4:0]    op,
    input  logic [1:0]    lane_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          sat_clear,
    output logic [DW-1:0] res,
    output logic          out_valid,
    output logic          sat_flag
);
    localparam int NB = DW / 8;
    localparam int NH = DW / 16;
    localparam int NW = DW / 32;

    op_t           op_d;
    lane_e         sel_d;
    logic [DW-1:0] y_b, y_h, y_w, y_sel;
    logic          f_b, f_h, f_w, f_sel;

    assign op_d  = op_t'(op);
    assign sel_d = lane_e'(lane_sel);

    simd_bank #(.W(8),  .N(NB)) u_byte (.op(op_d), .a(opa), .b(opb), .y(y_b), .ovf_any(f_b));
    simd_bank #(.W(16), .N(NH)) u_half (.op(op_d), .a(opa), .b(opb), .y(y_h), .ovf_any(f_h));
    simd_bank #(.W(32), .N(NW)) u_word (.op(op_d), .a(opa), .b(opb), .y(y_w), .ovf_any(f_w));

    always_comb begin
        case (sel_d)
            LS_BYTE: begin y_sel = y_b; f_sel = f_b; end
            LS_HALF: begin y_sel = y_h; f_sel = f_h; end
            default: begin y_sel = y_w; f_sel = f_w; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res       <= '0;
            out_valid <= 1'b0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res <= y_sel;
            end
            if (in_valid && f_sel) begin
                sat_flag <= 1'b1;
            end else if (sat_clear) begin
                sat_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/simd_chk.sv
module simd_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [4:0]  op,
    input logic [1:0]  lane_sel,
    input logic [31:0] opa,
    input logic        sat_clear,
    input logic [31:0] res,
    input logic        out_valid,
    input logic        sat_flag
);
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clear) |=> sat_flag);

    // R9
    flag_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !sat_flag) |=> !sat_flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_clear && !in_valid) |=> !sat_flag);

    // R7
    abs_word_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[3:0] == 4'd8 && lane_sel[1]) |=> !res[31]);

    // R12
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[3:0] > 4'd8) |=> (res == 32'd0));

    // R7
    abs_identity_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[3:0] == 4'd8 && lane_sel[1] && !opa[31]) |=> (res == $past(opa)));

endmodule

bind simd_addsub simd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .lane_sel  (lane_sel),
    .opa       (opa),
    .sat_clear (sat_clear),
    .res       (res),
    .out_valid (out_valid),
    .sat_flag  (sat_flag)
);

// File: tb/sim_simd_addsub.sv
`timescale 1ns/1ps
module sim_simd_addsub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [1:0]  lane_sel = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        sat_clear = 1'b0;
    logic [31:0] res;
    logic        out_valid;
    logic        sat_flag;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_res = '0;
    logic        exp_valid = 1'b0;
    logic        exp_flag = 1'b0;

    always #4 clk = ~clk;

    simd_addsub u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
        .opa(opa), .opb(opb), .sat_clear(sat_clear),
        .res(res), .out_valid(out_valid), .sat_flag(sat_flag)
    );

    function automatic logic [31:0] model(input logic [4:0] o, input logic [1:0] s,
                                          input logic [31:0] x, input logic [31:0] y,
                                          output bit fl);
        int     w;
        int     mode;
        bit     sub;
        longint m, smax, smin, ai, bi, sai, sbi, ss, us, lv;
        logic [31:0] r;
        w    = (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
        mode = int'(o[3:0]);
        sub  = o[4];
        m    = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w - 1)) - 1;
        smin = -(longint'(1) << (w - 1));
        r    = '0;
        fl   = 1'b0;
        for (int i = 0; i < 32 / w; i++) begin
            ai  = longint'(x >> (i * w)) & m;
            bi  = longint'(y >> (i * w)) & m;
            sai = (ai > smax) ? ai - (m + 1) : ai;
            sbi = (bi > smax) ? bi - (m + 1) : bi;
            ss  = sub ? sai - sbi : sai + sbi;
            us  = sub ? ai - bi : ai + bi;
            lv  = 0;
            case (mode)
                0: begin lv = ss; if (ss > smax || ss < smin) fl = 1'b1; end
                1: begin lv = us; if (us > m || us < 0) fl = 1'b1; end
                2: begin
                    lv = ss;
                    if (ss > smax) begin lv = smax; fl = 1'b1; end
                    if (ss < smin) begin lv = smin; fl = 1'b1; end
                end
                3: begin
                    lv = us;
                    if (us > m) begin lv = m; fl = 1'b1; end
                    if (us < 0) begin lv = 0; fl = 1'b1; end
                end
                4: lv = ss >>> 1;
                5: lv = (ss + 1) >>> 1;
                6: lv = us >>> 1;
                7: lv = (us + 1) >>> 1;
                8: begin
                    if (sai == smin) begin lv = smax; fl = 1'b1; end
                    else lv = (sai < 0) ? -sai : sai;
                end
                default: lv = 0;
            endcase
            r = r | (32'(lv & m) << (i * w));
        end
        return r;
    endfunction

    task automatic compare(input string tag);
        n_cmp++;
        if (res !== exp_res || out_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL %s: res=%h valid=%b expected res=%h valid=%b",
                     tag, res, out_valid, exp_res, exp_valid);
        end
        n_cmp++;
        if (sat_flag !== exp_flag) begin
            n_bad++;
            $display("FAIL %s (R9/R10 flag): sat_flag=%b expected %b", tag, sat_flag, exp_flag);
        end
    endtask

    task automatic step(input logic v, input logic [4:0] o, input logic [1:0] s,
                        input logic [31:0] x, input logic [31:0] y, input logic c,
                        input string tag);
        logic [31:0] er;
        bit          ef;
        @(negedge clk);
        in_valid = v; op = o; lane_sel = s; opa = x; opb = y; sat_clear = c;
        @(posedge clk);
        #1;
        er = model(o, s, x, y, ef);
        exp_valid = v;
        if (v) exp_res = er;
        if (v && ef) exp_flag = 1'b1;
        else if (c) exp_flag = 1'b0;
        compare(tag);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h7F7F7FFF;
            1: return 32'h80808000;
            2: return 32'hFFFFFFFF;
            3: return 32'h00000000;
            4: return 32'h7FFF8001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R11 reset");
        @(negedge clk);
        rst = 1'b0;

        // R1 lane layout / R2 modular
        step(1, 5'h00, 2'b00, 32'h01020304, 32'h10203040, 0, "R1 byte add");
        step(1, 5'h00, 2'b01, 32'h12345678, 32'h00010001, 0, "R1 half add");
        step(1, 5'h00, 2'b10, 32'h7FFFFFFF, 32'h00000001, 0, "R2 word signed ovf");
        step(1, 5'h10, 2'b00, 32'h00000001, 32'h00000002, 1, "R2 sub borrow");
        step(1, 5'h01, 2'b00, 32'hFF000000, 32'h01000000, 1, "R2 unsigned carry");
        step(0, 5'h00, 2'b00, 32'h0, 32'h0, 1, "R10 clear alone");
        // R3 signed saturation
        step(1, 5'h02, 2'b00, 32'h7F80107F, 32'h01FF1001, 0, "R3 byte sat");
        step(1, 5'h12, 2'b01, 32'h80007FFF, 32'h0001FFFF, 1, "R3 half sat sub");
        step(1, 5'h02, 2'b10, 32'h80000000, 32'hFFFFFFFF, 1, "R3 word sat min");
        // R4 unsigned saturation
        step(1, 5'h03, 2'b00, 32'hF0F00102, 32'h20010203, 1, "R4 add clamp");
        step(1, 5'h13, 2'b01, 32'h00050010, 32'h00060001, 1, "R4 sub clamp zero");
        step(0, 5'h00, 2'b00, 32'h0, 32'h0, 1, "R10 clear idle");
        // R5 / R6 halving
        step(1, 5'h04, 2'b01, 32'h7FFF8001, 32'h7FFF8000, 0, "R5 half signed add");
        step(1, 5'h16, 2'b00, 32'h00FF1003, 32'hFF000201, 0, "R5 byte unsigned sub");
        step(1, 5'h05, 2'b00, 32'h01037F80, 32'h00017F80, 0, "R6 round signed");
        step(1, 5'h17, 2'b00, 32'h030000FF, 32'h00FF0000, 0, "R6 round unsigned sub");
        step(1, 5'h15, 2'b10, 32'h7FFFFFFF, 32'h80000000, 0, "R6 round word wrap");
        // R7 absolute value
        step(1, 5'h08, 2'b00, 32'h80FF7F05, 32'hDEADBEEF, 0, "R7 abs byte");
        step(1, 5'h18, 2'b01, 32'hFFFE1234, 32'h12345678, 1, "R7 abs half b ignored");
        step(1, 5'h08, 2'b10, 32'h80000000, 32'h0, 1, "R7 abs word min");
        // R12 undefined modes
        step(1, 5'h09, 2'b00, 32'h7F7F7F7F, 32'h7F7F7F7F, 1, "R12 mode 9");
        step(1, 5'h1F, 2'b10, 32'hFFFFFFFF, 32'h1, 0, "R12 mode 15");
        // R8 hold
        step(0, 5'h00, 2'b00, 32'h11111111, 32'h2, 0, "R8 hold");
        step(0, 5'h00, 2'b00, 32'h33333333, 32'h4, 0, "R8 hold again");
        // R10 set and clear together
        step(1, 5'h03, 2'b00, 32'hFF000000, 32'h01000000, 1, "R10 set wins");
        step(1, 5'h00, 2'b00, 32'h01010101, 32'h01010101, 1, "R10 clear with clean op");

        // R1 random mix across all modes and lane sizes
        for (int k = 0; k < 3000; k++) begin
            step(($urandom_range(0, 9) < 8), 5'($urandom_range(0, 31)),
                 2'($urandom_range(0, 3)), pick(), pick(),
                 ($urandom_range(0, 9) == 0), "R1 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule